// File: doc/BRIEF.md
# Multiprocessor Interrupt Controller

This block gathers fifteen prioritised interrupt lines, numbered 1 to 15, and presents them to a configurable number of processors. Every processor owns a mask register, a force register, a 4-bit level output and an acknowledge strobe. A level register, a pending register and a write-only clear register are shared by all processors. Requests are combined separately for each processor. Each processor is offered the highest-numbered request of the strongest priority class that has something active.

A multiprocessor status register reports which processors are powered down. Software writes to the same register to release secondary processors through one-shot start strobes. All registers are reached through a simple 32-bit read/write bus with byte addresses and a combinational read path. The processor count `NCPU` may be 1 to 16. Any other value stops elaboration.

Top module: `mp_irq_ctrl`

## Requirements
- R1: After reset the level, pending, mask and force registers read zero, every `cpu_level` output is 0 and no `cpu_start` bit is high.
- R2: For processor c, the request set is (pending OR force[c]) AND mask[c]. In every register, bit n stands for interrupt n (n = 1..15), and bit 0 always reads 0. `cpu_level[4c+3:4c]` gives the highest-numbered interrupt of the winning class, or 0 when the set is empty. The output follows register changes without an added clock stage.
- R3: Interrupts whose level-register bit is 1 form the high class. When any high-class request is active for a processor, only that class competes for its output. Low-class requests are presented only when no high-class request is active.
- R4: A one-cycle acknowledge from processor c with number n clears bit n of pending and of force[c] at the next clock edge. The force registers of the other processors keep bit n.
- R5: A write to the clear register (offset 0x0C) clears the written bits 15:1 in pending and in every force register. Bit 0 of the written value has no effect, and the clear register reads as zero.
- R6: After reset the status register (offset 0x10) holds NCPU-1 in bits 31:28. Bits 1 through NCPU-1 hold 1, which means powered down. Bit 0 holds 0.
- R7: When a status write carries 1 in bit i, with 1 <= i < NCPU, start line i goes high for exactly one cycle after the write edge, and status bit i becomes 0. Written zeros, bit 0 and bits at or above NCPU have no effect. No write can set a status bit back to 1.
- R8: The level register is at 0x00, pending at 0x04, mask[c] at 0x40+4c and force[c] at 0x80+4c. Any other address, the range from 0xC0 upward, and mask or force slots for c >= NCPU read zero and ignore writes.
- R9: A 0-to-1 change on input line n sets pending bit n one clock edge later. A line that stays high does not set the bit again after it has been cleared.
- R10: If a rising input edge and an acknowledge for the same interrupt fall in one cycle, the pending bit stays set.
- R11: A write to the pending register replaces bits 15:1 with the written value. Bit 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 15 | Interrupt lines 1..15, edge-detected |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address; bits 1:0 ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| cpu_ack | input | NCPU | Per-processor acknowledge strobe |
| cpu_ack_num | input | 4*NCPU | Interrupt number acknowledged, 4 bits per processor |
| cpu_level | output | 4*NCPU | Presented interrupt number, 4 bits per processor |
| cpu_start | output | NCPU | One-cycle start strobe per processor |

## Verification
Two cases are hard to reach from the ports. The first is a new rising edge on a line that arrives in the same cycle as an acknowledge of that line. The bench first loads the pending bit by a register write while the line is held low. It then raises the line and pulses the acknowledge on the same falling clock edge. The second is the interaction of the two priority classes across four processors, each with its own mask and force. The bench covers this with a long arithmetic sweep of generated register patterns. For every pattern it computes each processor's expected output and compares it with `cpu_level`.

// File: rtl/mpic_pkg.sv
package mpic_pkg;
   localparam int LINES   = 15;
   localparam int LVL_W   = 4;
   localparam int MAX_CPU = 16;
   localparam int DATA_W  = 32;
   localparam int CNT_LSB = 28;

   typedef logic [LINES:1] irq_vec_t;

   typedef enum logic [1:0] {
      RGN_CTRL  = 2'd0,
      RGN_MASK  = 2'd1,
      RGN_FORCE = 2'd2,
      RGN_RSVD  = 2'd3
   } region_e;

   localparam logic [3:0] SLOT_LEVEL  = 4'd0;
   localparam logic [3:0] SLOT_PEND   = 4'd1;
   localparam logic [3:0] SLOT_CLEAR  = 4'd3;
   localparam logic [3:0] SLOT_MPSTAT = 4'd4;

   function automatic logic [LVL_W-1:0] top_index(input irq_vec_t v);
      logic [LVL_W-1:0] r;
      r = '0;
      for (int i = 1; i <= LINES; i++) begin
         if (v[i]) r = LVL_W'(i);
      end
      return r;
   endfunction
endpackage

// File: rtl/mpic_edge.sv
module mpic_edge
   import mpic_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  irq_vec_t lines,
   output irq_vec_t rises
);
   irq_vec_t lines_q;

   always_ff @(posedge clk) begin
      if (!rst_n) lines_q <= '0;
      else        lines_q <= lines;
   end

   assign rises = lines & ~lines_q;
endmodule

// File: rtl/mpic_cpu_port.sv
module mpic_cpu_port
   import mpic_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  irq_vec_t         pend_q,
   input  irq_vec_t         lvl_class,
   input  irq_vec_t         wdata,
   input  irq_vec_t         clr_vec,
   input  logic             wr_mask,
   input  logic             wr_force,
   input  logic             ack,
   input  logic [LVL_W-1:0] ack_num,
   output irq_vec_t         mask_q,
   output irq_vec_t         force_q,
   output irq_vec_t         ack_vec,
   output logic [LVL_W-1:0] level_out
);
   irq_vec_t req, hi_req, lo_req, winners;

   always_comb begin
      for (int b = 1; b <= LINES; b++) begin
         ack_vec[b] = ack && (ack_num == LVL_W'(b));
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q  <= '0;
         force_q <= '0;
      end else begin
         if (wr_mask) mask_q <= wdata;
         force_q <= (wr_force ? wdata : force_q) & ~clr_vec & ~ack_vec;
      end
   end

   always_comb begin
      req     = (pend_q | force_q) & mask_q;
      hi_req  = req & lvl_class;
      lo_req  = req & ~lvl_class;
      winners = (hi_req != '0) ? hi_req : lo_req;
   end

   assign level_out = top_index(winners);

   assert_idle_zero_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (((pend_q | force_q) & mask_q) == '0) |-> (level_out == '0));

   assert_high_class_first_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      ((((pend_q | force_q) & mask_q) & lvl_class) != '0)
         |-> (level_out != '0 && lvl_class[level_out]));

   assert_ack_clears_force_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (ack_vec != '0 && !wr_force) |=> ((force_q & $past(ack_vec)) == '0));
endmodule

// File: rtl/mpic_mp_status.sv
module mpic_mp_status
   import mpic_pkg::*;
#(
   parameter int NCPU = 4
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [NCPU-1:0]   start_req,
   output logic [DATA_W-1:0] stat_word,
   output logic [NCPU-1:0]   cpu_start
);
   localparam logic [NCPU-1:0] BOOT_BIT  = NCPU'(1);
   localparam logic [NCPU-1:0] DOWN_INIT = ~BOOT_BIT;
   localparam logic [3:0]      CNT_VAL   = 4'(NCPU - 1);

   logic [NCPU-1:0] down_q;
   logic [NCPU-1:0] req;

   assign req = start_req & ~BOOT_BIT;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         down_q    <= DOWN_INIT;
         cpu_start <= '0;
      end else begin
         cpu_start <= wr_en ? req : '0;
         if (wr_en) down_q <= down_q & ~req;
      end
   end

   always_comb begin
      stat_word                          = '0;
      stat_word[DATA_W-1:CNT_LSB]        = CNT_VAL;
      stat_word[NCPU-1:0]                = down_q;
   end

   assert_no_return_to_down_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      ((down_q & ~$past(down_q)) == '0));

   assert_start_marks_running_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      ((cpu_start & down_q) == '0));

   assert_boot_cpu_never_started_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_start[0]);

   assert_start_one_shot_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_start != '0 && !wr_en) |=> (cpu_start == '0));
endmodule

// File: rtl/mp_irq_ctrl.sv
module mp_irq_ctrl
   import mpic_pkg::*;
#(
   parameter int NCPU = 4
)(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [LINES:1]        irq_lines,
   input  logic                  bus_sel,
   input  logic                  bus_wr,
   input  logic [7:0]            bus_addr,
   input  logic [DATA_W-1:0]     bus_wdata,
   output logic [DATA_W-1:0]     bus_rdata,
   input  logic [NCPU-1:0]       cpu_ack,
   input  logic [NCPU*LVL_W-1:0] cpu_ack_num,
   output logic [NCPU*LVL_W-1:0] cpu_level,
   output logic [NCPU-1:0]       cpu_start
);
   generate
      if (NCPU < 1 || NCPU > MAX_CPU) begin : g_bad_ncpu
         $error("mp_irq_ctrl: NCPU out of range 1..16");
      end
   endgenerate

   region_e     region;
   logic [3:0]  slot;
   logic        wr;
   logic        wr_level, wr_pend, wr_clr, wr_stat;
   irq_vec_t    wvec, clr_vec, rises, ack_all;
   irq_vec_t    lvl_q, pend_q;
   irq_vec_t    mask_arr  [NCPU];
   irq_vec_t    force_arr [NCPU];
   irq_vec_t    ack_arr   [NCPU];
   logic [DATA_W-1:0] stat_word;
   logic        unused_bits;

   assign region      = region_e'(bus_addr[7:6]);
   assign slot        = bus_addr[5:2];
   assign wr          = bus_sel && bus_wr;
   assign wvec        = bus_wdata[LINES:1];
   assign unused_bits = ^{bus_addr[1:0], bus_wdata[DATA_W-1:LINES+1], bus_wdata[0]};

   assign wr_level = wr && region == RGN_CTRL && slot == SLOT_LEVEL;
   assign wr_pend  = wr && region == RGN_CTRL && slot == SLOT_PEND;
   assign wr_clr   = wr && region == RGN_CTRL && slot == SLOT_CLEAR;
   assign wr_stat  = wr && region == RGN_CTRL && slot == SLOT_MPSTAT;
   assign clr_vec  = wr_clr ? wvec : '0;

   mpic_edge u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .lines (irq_lines),
      .rises (rises)
   );

   genvar c;
   generate
      for (c = 0; c < NCPU; c++) begin : g_cpu
         logic wr_mask_c, wr_force_c;
         assign wr_mask_c  = wr && region == RGN_MASK  && slot == 4'(c);
         assign wr_force_c = wr && region == RGN_FORCE && slot == 4'(c);

         mpic_cpu_port u_port (
            .clk       (clk),
            .rst_n     (rst_n),
            .pend_q    (pend_q),
            .lvl_class (lvl_q),
            .wdata     (wvec),
            .clr_vec   (clr_vec),
            .wr_mask   (wr_mask_c),
            .wr_force  (wr_force_c),
            .ack       (cpu_ack[c]),
            .ack_num   (cpu_ack_num[c*LVL_W +: LVL_W]),
            .mask_q    (mask_arr[c]),
            .force_q   (force_arr[c]),
            .ack_vec   (ack_arr[c]),
            .level_out (cpu_level[c*LVL_W +: LVL_W])
         );
      end
   endgenerate

   always_comb begin
      ack_all = '0;
      for (int i = 0; i < NCPU; i++) ack_all = ack_all | ack_arr[i];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lvl_q  <= '0;
         pend_q <= '0;
      end else begin
         if (wr_level) lvl_q <= wvec;
         pend_q <= ((wr_pend ? wvec : pend_q) & ~clr_vec & ~ack_all) | rises;
      end
   end

   mpic_mp_status #(.NCPU(NCPU)) u_status (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_stat),
      .start_req (bus_wdata[NCPU-1:0]),
      .stat_word (stat_word),
      .cpu_start (cpu_start)
   );

   always_comb begin
      bus_rdata = '0;
      unique case (region)
         RGN_CTRL: begin
            if (slot == SLOT_LEVEL)       bus_rdata = DATA_W'({lvl_q, 1'b0});
            else if (slot == SLOT_PEND)   bus_rdata = DATA_W'({pend_q, 1'b0});
            else if (slot == SLOT_MPSTAT) bus_rdata = stat_word;
         end
         RGN_MASK: begin
            for (int i = 0; i < NCPU; i++)
               if (slot == 4'(i)) bus_rdata = DATA_W'({mask_arr[i], 1'b0});
         end
         RGN_FORCE: begin
            for (int i = 0; i < NCPU; i++)
               if (slot == 4'(i)) bus_rdata = DATA_W'({force_arr[i], 1'b0});
         end
         default: bus_rdata = '0;
      endcase
   end

   generate
      for (genvar b = 1; b <= LINES; b++) begin : g_edge_chk
         assert_edge_sets_pending_R9 : assert property (@(posedge clk) disable iff (!rst_n)
            rises[b] |=> pend_q[b]);
      end
   endgenerate

   assert_clear_reads_zero_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && bus_addr[7:2] == 6'h03) |-> (bus_rdata == '0));

   assert_reserved_reads_zero_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && bus_addr[7:6] == 2'b11) |-> (bus_rdata == '0));

   assert_pending_bit0_zero_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && bus_addr[7:2] == 6'h01) |-> (bus_rdata[0] == 1'b0));
endmodule

// File: tb/mp_irq_ctrl_test.sv
module mp_irq_ctrl_test;
   localparam int CLK_PERIOD = 10;
   localparam int NCPU = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:1] irq_lines = '0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [NCPU-1:0]   cpu_ack = '0;
   logic [NCPU*4-1:0] cpu_ack_num = '0;
   logic [NCPU*4-1:0] cpu_level;
   logic [NCPU-1:0]   cpu_start;

   mp_irq_ctrl #(.NCPU(NCPU)) uut (
      .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .cpu_ack(cpu_ack), .cpu_ack_num(cpu_ack_num),
      .cpu_level(cpu_level), .cpu_start(cpu_start)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 0;

   logic [15:0] m_pend, m_lvl;
   logic [15:0] m_mask  [NCPU];
   logic [15:0] m_force [NCPU];
   logic [31:0] m_stat;
   logic [31:0] seed = 32'h1234_5678;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 0; bus_wr = 0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1; bus_wr = 0; bus_addr = a;
      #1 d = bus_rdata;
      bus_sel = 0;
   endtask

   function automatic logic [3:0] exp_level(input int c);
      logic [15:0] req, win;
      logic [3:0] r;
      req = (m_pend | m_force[c]) & m_mask[c];
      win = ((req & m_lvl) != 0) ? (req & m_lvl) : (req & ~m_lvl);
      r = 0;
      for (int b = 1; b < 16; b++) if (win[b]) r = 4'(b);
      return r;
   endfunction

   function automatic logic [31:0] next_rand();
      seed = seed * 32'd1103515245 + 32'd12345;
      return seed;
   endfunction

   task automatic check_all(input string tag);
      logic [31:0] d;
      #1;
      for (int c = 0; c < NCPU; c++)
         check({tag, " level out"}, 32'(cpu_level[c*4 +: 4]), 32'(exp_level(c)));
      rd(8'h00, d); check({tag, " level reg"}, d, 32'(m_lvl));
      rd(8'h04, d); check({tag, " pending reg"}, d, 32'(m_pend));
      for (int c = 0; c < NCPU; c++) begin
         rd(8'(8'h40 + 4*c), d); check({tag, " mask reg"}, d, 32'(m_mask[c]));
         rd(8'(8'h80 + 4*c), d); check({tag, " force reg"}, d, 32'(m_force[c]));
      end
   endtask

   task automatic ack(input int c, input int n);
      @(negedge clk);
      cpu_ack[c] = 1; cpu_ack_num[c*4 +: 4] = 4'(n);
      @(negedge clk);
      cpu_ack = '0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_vec++; n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      m_pend = 0; m_lvl = 0; m_stat = 32'h3000_000E;
      for (int c = 0; c < NCPU; c++) begin m_mask[c] = 0; m_force[c] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1;

      // R1 reset state, R6 status reset value
      check_all("R1");
      check("R1 start idle", 32'(cpu_start), 0);
      rd(8'h10, d); check("R6 status reset", d, m_stat);

      // R8 mapped registers and ignored addresses
      for (int c = 0; c < NCPU; c++) begin
         m_mask[c] = 16'(16'h1110 << c) & 16'hFFFE;
         m_force[c] = 16'(16'h0100 << c) & 16'hFFFE;
         wr(8'(8'h40 + 4*c), 32'(m_mask[c]));
         wr(8'(8'h80 + 4*c), 32'(m_force[c]));
      end
      foreach (d[i]) ; // no-op
      wr(8'h08, 32'hFFFF_FFFF);
      wr(8'h14, 32'hFFFF_FFFF);
      wr(8'h3C, 32'hFFFF_FFFF);
      wr(8'h54, 32'hFFFF_FFFF);
      wr(8'h94, 32'hFFFF_FFFF);
      wr(8'hC0, 32'hFFFF_FFFF);
      wr(8'hFC, 32'hFFFF_FFFF);
      rd(8'h08, d); check("R8 unused 0x08", d, 0);
      rd(8'h54, d); check("R8 mask slot beyond NCPU", d, 0);
      rd(8'h94, d); check("R8 force slot beyond NCPU", d, 0);
      rd(8'hC0, d); check("R8 reserved 0xC0", d, 0);
      rd(8'hFC, d); check("R8 reserved 0xFC", d, 0);
      rd(8'h10, d); check("R8 status untouched", d, m_stat);
      check_all("R8");

      // R11 pending write loads, bit 0 ignored
      wr(8'h04, 32'hFFFF_FFFF); m_pend = 16'hFFFE;
      check_all("R11 load all");
      wr(8'h04, 32'h0000_0A51); m_pend = 16'h0A50;
      check_all("R11 replace");

      // R9 edge sweep over every line
      for (int c = 0; c < NCPU; c++) begin
         m_mask[c] = 16'hFFFE; m_force[c] = 0;
         wr(8'(8'h40 + 4*c), 32'hFFFE);
         wr(8'(8'h80 + 4*c), 0);
      end
      wr(8'h04, 0); m_pend = 0;
      for (int n = 1; n < 16; n++) begin
         @(negedge clk); irq_lines[n] = 1'b1;
         @(negedge clk); #1;
         m_pend = 16'(1 << n);
         for (int c = 0; c < NCPU; c++)
            check("R9 edge level", 32'(cpu_level[c*4 +: 4]), 32'(n));
         rd(8'h04, d); check("R9 edge pending", d, 32'(m_pend));
         wr(8'h0C, 32'(m_pend)); m_pend = 0;
         repeat (2) @(negedge clk);
         rd(8'h04, d); check("R9 steady high no re-set", d, 0);
         irq_lines = '0;
      end

      // R2 and R3 sweep over generated patterns
      for (int it = 0; it < 200; it++) begin
         m_pend = next_rand()[15:0] & 16'hFFFE;
         m_lvl  = next_rand()[19:4] & 16'hFFFE;
         wr(8'h04, 32'(m_pend));
         wr(8'h00, 32'(m_lvl));
         for (int c = 0; c < NCPU; c++) begin
            m_mask[c]  = next_rand()[23:8] & 16'hFFFE;
            m_force[c] = next_rand()[17:2] & next_rand()[15:0] & 16'hFFFE;
            wr(8'(8'h40 + 4*c), 32'(m_mask[c]));
            wr(8'(8'h80 + 4*c), 32'(m_force[c]));
         end
         #1;
         for (int c = 0; c < NCPU; c++)
            check("R2 R3 presented level", 32'(cpu_level[c*4 +: 4]), 32'(exp_level(c)));
      end

      // R3 directed: high class wins over higher-numbered low class
      m_lvl = 16'h0004; m_pend = 16'h8004;
      for (int c = 0; c < NCPU; c++) begin
         m_mask[c] = 16'hFFFE; m_force[c] = 0;
         wr(8'(8'h40 + 4*c), 32'hFFFE); wr(8'(8'h80 + 4*c), 0);
      end
      wr(8'h00, 32'(m_lvl)); wr(8'h04, 32'(m_pend));
      #1 check("R3 high class 2 over 15", 32'(cpu_level[3:0]), 2);

      // R4 acknowledge per cpu, every interrupt number
      wr(8'h00, 0); m_lvl = 0;
      for (int n = 1; n < 16; n++) begin
         m_pend = 16'(1 << n);
         wr(8'h04, 32'(m_pend));
         for (int c = 0; c < NCPU; c++) begin
            m_force[c] = 16'(1 << n);
            wr(8'(8'h80 + 4*c), 32'(m_force[c]));
         end
         ack(n % NCPU, n);
         m_pend = 0; m_force[n % NCPU] = 0;
         check_all("R4");
      end

      // R5 clear register
      m_pend = 16'hFFFE; wr(8'h04, 32'hFFFE);
      for (int c = 0; c < NCPU; c++) begin
         m_force[c] = 16'hFFFE; wr(8'(8'h80 + 4*c), 32'hFFFE);
      end
      wr(8'h0C, 32'h0000_00FF);
      m_pend = 16'hFF00;
      for (int c = 0; c < NCPU; c++) m_force[c] = 16'hFF00;
      check_all("R5 clear bits 7:1");
      rd(8'h0C, d); check("R5 clear reads zero", d, 0);
      wr(8'h0C, 32'h0000_0001);
      check_all("R5 bit 0 ignored");

      // R10 edge and ack on same bit in one cycle
      m_pend = 16'h0020; wr(8'h04, 32'h0020);
      for (int c = 0; c < NCPU; c++) begin m_force[c] = 0; wr(8'(8'h80 + 4*c), 0); end
      @(negedge clk);
      irq_lines[5] = 1'b1; cpu_ack[0] = 1'b1; cpu_ack_num[3:0] = 4'd5;
      @(negedge clk);
      cpu_ack = '0;
      rd(8'h04, d); check("R10 edge beats ack", d, 32'h0020);
      irq_lines = '0;

      // R7 start strobes
      @(negedge clk);
      bus_sel = 1; bus_wr = 1; bus_addr = 8'h10; bus_wdata = 32'h0000_0004;
      @(negedge clk);
      bus_sel = 0; bus_wr = 0;
      check("R7 start pulse cpu2", 32'(cpu_start), 32'h4);
      @(negedge clk);
      check("R7 start one cycle", 32'(cpu_start), 0);
      m_stat = 32'h3000_000A;
      rd(8'h10, d); check("R7 status cleared", d, m_stat);
      @(negedge clk);
      bus_sel = 1; bus_wr = 1; bus_addr = 8'h10; bus_wdata = 32'hFFFF_FFF1;
      @(negedge clk);
      bus_sel = 0; bus_wr = 0;
      check("R7 bit0 and high bits no start", 32'(cpu_start), 0);
      rd(8'h10, d); check("R7 status kept", d, m_stat);
      wr(8'h10, 0);
      rd(8'h10, d); check("R7 zero write no effect", d, m_stat);
      @(negedge clk);
      bus_sel = 1; bus_wr = 1; bus_addr = 8'h10; bus_wdata = 32'h0000_000E;
      @(negedge clk);
      bus_sel = 0; bus_wr = 0;
      check("R7 start all secondaries", 32'(cpu_start), 32'hE);
      m_stat = 32'h3000_0000;
      rd(8'h10, d); check("R7 all running", d, m_stat);
      check("R6 count field", d >> 28, 3);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule